// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block is a three-register window placed in a serial management register map. Through it, a host that can only reach 32 sixteen-bit management registers can read and write a larger space of 8-bit internal registers. The host side is a plain register port: a 5-bit address, 16-bit write data, a write strobe and combinational read data, as a management-frame slave would drive it. The internal side is a request/acknowledge bus with an address, an 8-bit write byte, an 8-bit read byte and a latency set by the target.

The host first loads a pointer register with the internal address. It then writes the opcode/status register with an opcode bit and, for a write, the data byte. The bridge raises BUSY and holds a request on the internal bus until the target acknowledges. After a read, the returned byte is available in the result register. The host polls BUSY before it starts another transaction. Any pointer or opcode access made while BUSY is set is dropped.

Top module: `iwb_bridge`

## Requirements
- R1: After reset the pointer, data byte and result are zero, BUSY is clear, `int_req` is low, and every management address reads 0000h.
- R2: Address 10h is the pointer. A write stores `host_wdata[IADDR_W-1:0]` and ignores the upper bits. A read returns the pointer zero-extended to 16 bits, and `int_addr` always shows the pointer.
- R3: Address 11h reads as {data byte in bits 15:8, BUSY in bit 7, bits 6:0 zero}. The opcode bits (bit 0 write, bit 1 read) always read back as 0.
- R4: A write to 11h with bit 0 set while BUSY is clear stores bits 15:8 as the data byte. From the next cycle, `int_req`=1, `int_we`=1, `int_wdata` is that byte, `int_addr` is the pointer, and BUSY reads 1.
- R5: A write to 11h with bits 1:0 = 10b while BUSY is clear starts a read: from the next cycle `int_req`=1, `int_we`=0 and BUSY=1.
- R6: A write to 11h with bits 1:0 = 11b starts a write only.
- R7: While `int_req` is high and `int_ack` is low, `int_req`, `int_we`, `int_addr` and `int_wdata` hold their values. `int_ack` sampled high with `int_req` ends the transaction: in the next cycle `int_req` is low and BUSY reads 0.
- R8: When a read ends, `int_rdata` sampled on the acknowledge cycle goes into bits 7:0 of the result register at 12h, and bits 15:8 read 0. The result changes at no other time, including when a write completes.
- R9: Writes to 10h or 11h while BUSY is set are ignored. The pointer, the data byte and the pending transaction stay unchanged, and no second request is issued.
- R10: Address 12h is read-only. Every address other than 10h, 11h and 12h reads 0000h, and writes to those addresses have no effect.
- R11: A write to 11h with bits 1:0 = 00b while BUSY is clear updates the data byte but starts no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Management register write strobe |
| host_addr | input | 5 | Management register address |
| host_wdata | input | 16 | Management write data |
| host_rdata | output | 16 | Management read data (combinational on host_addr) |
| int_req | output | 1 | Internal bus request, held until acknowledged |
| int_we | output | 1 | Internal bus direction, 1 = write |
| int_addr | output | IADDR_W | Internal register address (the pointer) |
| int_wdata | output | 8 | Internal write byte |
| int_rdata | input | 8 | Internal read byte, valid with int_ack on reads |
| int_ack | input | 1 | Internal bus acknowledge, one cycle |

## Verification
The hardest situation to reach from the ports is a host access that lands while a transaction is still pending. A fast target closes the BUSY window before the host port can issue a second access. The bench's target model therefore has a programmable acknowledge latency: it sweeps latencies 0 to 3 over all 256 internal addresses, then stretches to 20 cycles so that pointer and opcode writes can be injected while BUSY is set. The effect of those dropped writes is then read back through the pointer and status registers and through the target's record of the requests it served.

// File: rtl/iwb_pkg.sv
package iwb_pkg;
  localparam int MGMT_AW = 5;
  localparam int HOST_W  = 16;
  localparam int BYTE_W  = 8;

  localparam logic [MGMT_AW-1:0] ADR_PTR = 5'h10;
  localparam logic [MGMT_AW-1:0] ADR_OPS = 5'h11;
  localparam logic [MGMT_AW-1:0] ADR_RES = 5'h12;

  localparam int OP_WR_BIT = 0;
  localparam int OP_RD_BIT = 1;
  localparam int BUSY_BIT  = 7;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_WRITE, SEQ_READ} seq_state_t;
  typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_READ} op_kind_t;

  // Write opcode wins when both bits are set.
  function automatic op_kind_t decode_op(input logic [HOST_W-1:0] w);
    if (w[OP_WR_BIT])      return OP_WRITE;
    else if (w[OP_RD_BIT]) return OP_READ;
    else                   return OP_NONE;
  endfunction

  function automatic logic [HOST_W-1:0] pack_status(input logic [BYTE_W-1:0] d,
                                                    input logic busy);
    logic [HOST_W-1:0] r;
    r = '0;
    r[HOST_W-1:BYTE_W] = d;
    r[BUSY_BIT] = busy;
    return r;
  endfunction

  function automatic logic [HOST_W-1:0] pack_result(input logic [BYTE_W-1:0] b);
    logic [HOST_W-1:0] r;
    r = '0;
    r[BYTE_W-1:0] = b;
    return r;
  endfunction
endpackage

// File: rtl/iwb_host_decode.sv
module iwb_host_decode
  import iwb_pkg::*;
(
  input  logic                host_we,
  input  logic [MGMT_AW-1:0]  host_addr,
  input  logic [HOST_W-1:0]   host_wdata,
  input  logic                busy,
  output logic                ptr_wr,
  output logic                ops_wr,
  output logic                start_wr,
  output logic                start_rd,
  output logic                cmd_dropped
);
  logic     hit_ptr;
  logic     hit_ops;
  op_kind_t op;

  assign hit_ptr = host_we && (host_addr == ADR_PTR);
  assign hit_ops = host_we && (host_addr == ADR_OPS);
  assign op      = decode_op(host_wdata);

  assign ptr_wr      = hit_ptr && !busy;
  assign ops_wr      = hit_ops && !busy;
  assign start_wr    = ops_wr && (op == OP_WRITE);
  assign start_rd    = ops_wr && (op == OP_READ);
  assign cmd_dropped = (hit_ptr || hit_ops) && busy;
endmodule

// File: rtl/iwb_seq.sv
module iwb_seq
  import iwb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_wr,
  input  logic start_rd,
  input  logic int_ack,
  output logic busy,
  output logic int_req,
  output logic int_we,
  output logic txn_done,
  output logic rd_done
);
  seq_state_t state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start_wr)      state_q <= SEQ_WRITE;
          else if (start_rd) state_q <= SEQ_READ;
        end
        SEQ_WRITE, SEQ_READ: begin
          if (int_ack) state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != SEQ_IDLE);
  assign int_req  = busy;
  assign int_we   = (state_q == SEQ_WRITE);
  assign txn_done = busy && int_ack;
  assign rd_done  = (state_q == SEQ_READ) && int_ack;
endmodule

// File: rtl/iwb_regfile.sv
module iwb_regfile
  import iwb_pkg::*;
#(
  parameter int IADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ptr_wr,
  input  logic               ops_wr,
  input  logic               rd_done,
  input  logic [HOST_W-1:0]  host_wdata,
  input  logic [BYTE_W-1:0]  int_rdata,
  output logic [IADDR_W-1:0] ptr,
  output logic [BYTE_W-1:0]  data_byte,
  output logic [BYTE_W-1:0]  result
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= '0;
      data_byte <= '0;
      result    <= '0;
    end else begin
      if (ptr_wr)  ptr       <= host_wdata[IADDR_W-1:0];
      if (ops_wr)  data_byte <= host_wdata[HOST_W-1:BYTE_W];
      if (rd_done) result    <= int_rdata;
    end
  end
endmodule

// File: rtl/iwb_bridge.sv
module iwb_bridge
  import iwb_pkg::*;
#(
  parameter int IADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [4:0]         host_addr,
  input  logic [15:0]        host_wdata,
  output logic [15:0]        host_rdata,
  output logic               int_req,
  output logic               int_we,
  output logic [IADDR_W-1:0] int_addr,
  output logic [7:0]         int_wdata,
  input  logic [7:0]         int_rdata,
  input  logic               int_ack
);
  localparam int PAD_W = HOST_W - IADDR_W;

  // Named internal events, visible to the bound checker.
  logic               busy;
  logic               ptr_wr;
  logic               ops_wr;
  logic               start_wr;
  logic               start_rd;
  logic               cmd_dropped;
  logic               txn_done;
  logic               rd_done;
  logic [IADDR_W-1:0] ptr;
  logic [BYTE_W-1:0]  data_byte;
  logic [BYTE_W-1:0]  result;

  iwb_host_decode u_dec (
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .busy        (busy),
    .ptr_wr      (ptr_wr),
    .ops_wr      (ops_wr),
    .start_wr    (start_wr),
    .start_rd    (start_rd),
    .cmd_dropped (cmd_dropped)
  );

  iwb_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_wr (start_wr),
    .start_rd (start_rd),
    .int_ack  (int_ack),
    .busy     (busy),
    .int_req  (int_req),
    .int_we   (int_we),
    .txn_done (txn_done),
    .rd_done  (rd_done)
  );

  iwb_regfile #(.IADDR_W(IADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptr_wr     (ptr_wr),
    .ops_wr     (ops_wr),
    .rd_done    (rd_done),
    .host_wdata (host_wdata),
    .int_rdata  (int_rdata),
    .ptr        (ptr),
    .data_byte  (data_byte),
    .result     (result)
  );

  assign int_addr  = ptr;
  assign int_wdata = data_byte;

  always_comb begin
    case (host_addr)
      ADR_PTR: host_rdata = {{PAD_W{1'b0}}, ptr};
      ADR_OPS: host_rdata = pack_status(data_byte, busy);
      ADR_RES: host_rdata = pack_result(result);
      default: host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/iwb_bridge_chk.sv
module iwb_bridge_chk #(
  parameter int IADDR_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_we,
  input logic [4:0]         host_addr,
  input logic [15:0]        host_wdata,
  input logic [15:0]        host_rdata,
  input logic               int_req,
  input logic               int_we,
  input logic [IADDR_W-1:0] int_addr,
  input logic [7:0]         int_wdata,
  input logic [7:0]         int_rdata,
  input logic               int_ack,
  input logic               busy,
  input logic               cmd_dropped,
  input logic [7:0]         result
);
  logic ops_idle_wr;
  assign ops_idle_wr = host_we && (host_addr == 5'h11) && !busy;

  assert_req_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_req) |-> $past(host_we && host_addr == 5'h11 && host_wdata[1:0] != 2'b00));

  assert_write_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ops_idle_wr && host_wdata[1:0] == 2'b01) |=>
      (int_req && int_we && int_wdata == $past(host_wdata[15:8])));

  assert_read_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ops_idle_wr && host_wdata[1:0] == 2'b10) |=> (int_req && !int_we));

  assert_both_is_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ops_idle_wr && host_wdata[1:0] == 2'b11) |=> (int_req && int_we));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && !int_ack) |=>
      (int_req && $stable(int_addr) && $stable(int_we) && $stable(int_wdata)));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && int_ack) |=> (!int_req && !busy));

  assert_result_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && !int_we && int_ack) |=> (result == $past(int_rdata)));

  assert_result_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_req && !int_we && int_ack) |=> $stable(result));

  assert_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dropped |=> ($stable(int_addr) && $stable(int_wdata)));

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr < 5'h10 || host_addr > 5'h12) |-> (host_rdata == 16'h0000));

  assert_status_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == 5'h11) |-> (host_rdata[6:0] == 7'd0));
endmodule

bind iwb_bridge iwb_bridge_chk #(.IADDR_W(IADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_we     (host_we),
  .host_addr   (host_addr),
  .host_wdata  (host_wdata),
  .host_rdata  (host_rdata),
  .int_req     (int_req),
  .int_we      (int_we),
  .int_addr    (int_addr),
  .int_wdata   (int_wdata),
  .int_rdata   (int_rdata),
  .int_ack     (int_ack),
  .busy        (busy),
  .cmd_dropped (cmd_dropped),
  .result      (result)
);

// File: tb/test_iwb_bridge.sv
`timescale 1ns/1ps
module test_iwb_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        int_req, int_we;
  logic [7:0]  int_addr, int_wdata;
  logic [7:0]  int_rdata;
  logic        int_ack;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  iwb_bridge #(.IADDR_W(8)) i_iwb_bridge (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .int_req(int_req),
    .int_we(int_we), .int_addr(int_addr), .int_wdata(int_wdata),
    .int_rdata(int_rdata), .int_ack(int_ack)
  );

  // Target model with programmable acknowledge latency.
  logic [7:0] tmem [256];
  int  lat = 0;
  int  cnt = 0;
  int  ack_count = 0;
  int  req_rises = 0;
  logic req_d = 1'b0;
  logic [7:0] seen_addr = '0, seen_wdata = '0;
  logic seen_we = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      int_ack <= 1'b0; int_rdata <= '0; cnt <= 0; req_d <= 1'b0;
    end else begin
      req_d <= int_req;
      if (int_req && !req_d) req_rises <= req_rises + 1;
      int_ack <= 1'b0;
      if (int_req && !int_ack) begin
        if (cnt >= lat) begin
          int_ack <= 1'b1; cnt <= 0;
          int_rdata <= tmem[int_addr];
          if (int_we) tmem[int_addr] <= int_wdata;
          seen_addr <= int_addr; seen_we <= int_we; seen_wdata <= int_wdata;
          ack_count <= ack_count + 1;
        end else cnt <= cnt + 1;
      end
    end
  end

  logic [7:0] exp_mem [256];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic hwrite(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input logic [4:0] a, output logic [15:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int k = 0; k < 100; k++) begin
      hread(5'h11, s);
      if (!s[7]) return;
      @(negedge clk);
    end
    check("R7 busy timeout", 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [7:0]  d;
    int a0, base;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state on every address
    for (int a = 0; a < 32; a++) begin
      hread(a[4:0], r);
      check("R1 reset read", r, 16'h0000);
    end
    check("R1 req low", int_req, 0);

    // R2: pointer sweep, upper bits dropped
    for (int i = 0; i < 256; i++) begin
      hwrite(5'h10, {~i[7:0], i[7:0]});
      hread(5'h10, r);
      check("R2 pointer readback", r, {8'h00, i[7:0]});
      check("R2 int_addr", int_addr, i[7:0]);
    end

    // R4/R6/R7: write sweep over all internal addresses
    for (int i = 0; i < 256; i++) begin
      d = 8'((i * 37 + 11) & 255);
      lat = i % 4;
      hwrite(5'h10, 16'(i));
      hwrite(5'h11, {d, (i % 8 == 0) ? 8'h03 : 8'h01});
      hread(5'h11, r);
      check("R4 busy set", r, {d, 8'h80});
      check("R4 req/we", {int_req, int_we}, 2'b11);
      check("R4 wdata", int_wdata, d);
      wait_idle();
      exp_mem[i] = d;
      check(i % 8 == 0 ? "R6 both bits write" : "R4 target write",
            {seen_we, seen_addr, seen_wdata}, {1'b1, i[7:0], d});
      hread(5'h11, r);
      check("R3 status after write", r, {d, 8'h00});
      check("R7 req dropped", int_req, 0);
    end

    // R5/R8: read sweep
    for (int i = 0; i < 256; i++) begin
      lat = 3 - (i % 4);
      hwrite(5'h10, 16'(i));
      hwrite(5'h11, 16'h0002);
      check("R5 req/we", {int_req, int_we}, 2'b10);
      wait_idle();
      check("R5 target read", {seen_we, seen_addr}, {1'b0, i[7:0]});
      hread(5'h12, r);
      check("R8 result", r, {8'h00, exp_mem[i]});
    end

    // R8: write completion leaves result alone
    hwrite(5'h10, 16'h0005); hwrite(5'h11, 16'h0002); wait_idle();
    hwrite(5'h10, 16'h0006); hwrite(5'h11, 16'hE101); wait_idle();
    exp_mem[6] = 8'hE1;
    hread(5'h12, r);
    check("R8 result kept after write", r, {8'h00, exp_mem[5]});

    // R9: accesses while busy are dropped
    lat = 20;
    base = ack_count;
    a0 = req_rises;
    hwrite(5'h10, 16'h0033);
    hwrite(5'h11, 16'hC401);
    hwrite(5'h10, 16'h0077);
    hwrite(5'h11, 16'h9902);
    hread(5'h10, r);
    check("R9 pointer kept", r, 16'h0033);
    hread(5'h11, r);
    check("R9 data kept busy", r, 16'hC480);
    wait_idle();
    repeat (4) @(negedge clk);
    check("R9 single txn", ack_count - base, 1);
    check("R9 single req", req_rises - a0, 1);
    check("R9 txn intact", {seen_we, seen_addr, seen_wdata}, {1'b1, 8'h33, 8'hC4});
    exp_mem[8'h33] = 8'hC4;
    lat = 0;

    // R11: opcode-free write updates data only
    a0 = req_rises;
    hwrite(5'h11, 16'h5A00);
    repeat (5) @(negedge clk);
    hread(5'h11, r);
    check("R11 data only", r, 16'h5A00);
    check("R11 no request", req_rises - a0, 0);

    // R10: read-only result, reserved addresses inert
    hread(5'h12, r);
    hwrite(5'h12, 16'hFFFF);
    begin
      logic [15:0] r2;
      hread(5'h12, r2);
      check("R10 result read-only", r2, r);
    end
    a0 = req_rises;
    for (int a = 0; a < 32; a++) begin
      if (a < 16 || a > 18) hwrite(a[4:0], 16'hFFFF);
    end
    for (int a = 0; a < 32; a++) begin
      if (a < 16 || a > 18) begin
        hread(a[4:0], r);
        check("R10 reserved zero", r, 16'h0000);
      end
    end
    hread(5'h10, r);
    check("R10 pointer untouched", r, 16'h0033);
    hread(5'h11, r);
    check("R10 status untouched", r, 16'h5A00);
    repeat (3) @(negedge clk);
    check("R10 no request", req_rises - a0, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule